// File: doc/BRIEF.md
# Receive Destination Address Filter

This block watches the destination address at the head of each received Ethernet frame and decides whether the frame is kept and to which receive channel it goes. The six address bytes arrive one per strobe, with the first byte flagged by a start marker. One cycle after the sixth byte is taken, the block presents a single-cycle decision: accept or drop, the target channel, and the class of the address (individual, group or broadcast).

Four mechanisms feed the decision, in a fixed priority order. An exact-match table holds up to `TBL_DEPTH` stored addresses, each with a valid flag, a match flag and a channel. The all-ones broadcast address has its own enable and channel. Other group addresses are tested against a 64-bit hash bitmap and have their own enable and channel. A promiscuous mode catches every frame that nothing else claimed. The table is loaded through a one-entry-per-cycle write port. The enables, channels and bitmap are static configuration inputs that are sampled when the sixth byte arrives.

Top module: `rx_dest_filter`

## Requirements
- R1: While `rst_ni` is low and after its release, `dec_vld_o`, `accept_o`, `chan_o` and `cls_o` are zero, and every table entry is invalid.
- R2: The address bits are assembled so that byte k (k = 0 for the byte with `start_i`) occupies address bits 8k+7..8k. The decision appears on the outputs exactly one cycle after the sixth byte is strobed, and lasts one cycle. Strobe gaps between bytes are allowed. Strobed bytes without `start_i` after the sixth byte are ignored. While `dec_vld_o` is low, `accept_o`, `chan_o` and `cls_o` are zero.
- R3: `cls_o` is 2'b10 for the all-ones address. Otherwise it is 2'b01 when address bit 0 (bit 0 of the first byte) is 1, and 2'b00 when that bit is 0.
- R4: A valid table entry equal to the address, with match flag 1, accepts the frame on that entry's channel. This overrides every other rule. When several entries are equal to the address, the lowest index wins.
- R5: A winning table entry with match flag 0 drops the frame (`accept_o`=0, `chan_o`=0). This holds even when broadcast, hash or promiscuous acceptance would otherwise apply.
- R6: Without a table hit, the broadcast address is accepted on `bc_ch_i` when `bc_en_i` is 1. When `bc_en_i` is 0, it falls through to the later rules.
- R7: Without a table hit, a group address other than broadcast is accepted on `mc_ch_i` when `mc_en_i` is 1 and the bitmap bit at index h is 1. Hash bit j of h is the XOR of address bits j, j+6, ..., j+42. Bitmap bits 0..31 are `hash_lo_i[h]` and bits 32..63 are `hash_hi_i[h-32]`.
- R8: When `prom_en_i` is 1, a frame not claimed by rules R4 to R7 is accepted on `prom_ch_i`.
- R9: A frame claimed by no rule is dropped with `accept_o`=0 and `chan_o`=0.
- R10: Asserting `tbl_we_i` writes the address, channel, valid flag and match flag to entry `tbl_idx_i` at the clock edge. A decision made at that same edge still uses the entry's previous contents, and later decisions use the new contents.
- R11: A byte strobed with `start_i` always begins a new address as byte 0, and any partly assembled address is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| byte_i | input | 8 | Destination address byte |
| byte_vld_i | input | 1 | Byte strobe |
| start_i | input | 1 | Marks the first address byte |
| tbl_we_i | input | 1 | Table entry write |
| tbl_idx_i | input | IDX_W (5) | Entry index to write |
| tbl_addr_i | input | 48 | Address stored in the entry |
| tbl_ch_i | input | CH_W (3) | Channel of the entry |
| tbl_vld_i | input | 1 | Valid flag of the entry |
| tbl_match_i | input | 1 | Match flag: 1 accepts, 0 drops |
| hash_lo_i | input | 32 | Bitmap bits 31..0 |
| hash_hi_i | input | 32 | Bitmap bits 63..32 |
| bc_en_i | input | 1 | Broadcast acceptance enable |
| bc_ch_i | input | CH_W (3) | Broadcast channel |
| mc_en_i | input | 1 | Hashed group acceptance enable |
| mc_ch_i | input | CH_W (3) | Hashed group channel |
| prom_en_i | input | 1 | Promiscuous enable |
| prom_ch_i | input | CH_W (3) | Promiscuous channel |
| dec_vld_o | output | 1 | Decision strobe |
| accept_o | output | 1 | Frame accepted |
| chan_o | output | CH_W (3) | Target channel |
| cls_o | output | 2 | Address class |

## Verification
A table write and a lookup can fall on the same clock edge. This happens when `tbl_we_i` is raised together with the sixth address byte, targeting the very address being decided. The bench provokes this collision on purpose: it writes a new entry on the last byte of that address and then sends the same address again. The first decision must ignore the entry and the second must hit it. The reference model in the bench decides before it applies the write, and both outcomes are compared against it. Randomized traffic, with table rewrites mixed into address bytes, repeats the collision with other indices and flags.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int unsigned ADDR_W  = 48;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned N_BYTES = ADDR_W / BYTE_W;
  localparam int unsigned HASH_W  = 6;
  localparam int unsigned HMAP_W  = 1 << HASH_W;
  localparam int unsigned HWORD_W = HMAP_W / 2;

  typedef enum logic [1:0] {
    CLS_UNI   = 2'd0,
    CLS_MULTI = 2'd1,
    CLS_BCAST = 2'd2
  } addr_cls_e;

  // hash bit j folds every HASH_W-th address bit starting at j
  function automatic logic [HASH_W-1:0] hash_idx(input logic [ADDR_W-1:0] a);
    logic [HASH_W-1:0] h;
    h = '0;
    for (int j = 0; j < HASH_W; j++)
      for (int i = 0; i < ADDR_W / HASH_W; i++)
        h[j] = h[j] ^ a[j + HASH_W * i];
    return h;
  endfunction
endpackage

// File: rtl/rxf_addr_asm.sv
module rxf_addr_asm
  import rxf_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              byte_vld_i,
  input  logic              start_i,
  output logic              done_o,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int unsigned CNT_W  = $clog2(N_BYTES + 1);
  localparam int unsigned PART_W = ADDR_W - BYTE_W;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(N_BYTES - 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [PART_W-1:0] part_q;

  assign done_o = byte_vld_i && !start_i && (cnt_q == LAST);
  assign addr_o = {byte_i, part_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      part_q <= '0;
    end else if (byte_vld_i) begin
      if (start_i) begin
        part_q[BYTE_W-1:0] <= byte_i;
        cnt_q              <= CNT_W'(1);
      end else if (cnt_q != '0) begin
        if (done_o) begin
          cnt_q <= '0;
        end else begin
          part_q[BYTE_W*int'(cnt_q) +: BYTE_W] <= byte_i;
          cnt_q <= cnt_q + CNT_W'(1);
        end
      end
    end
  end

  assert_cnt_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);

  assert_restart_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_vld_i && start_i) |=> (cnt_q == CNT_W'(1)));
endmodule

// File: rtl/rxf_addr_tbl.sv
module rxf_addr_tbl
  import rxf_pkg::*;
#(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned CH_W  = 3,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [CH_W-1:0]   wr_ch_i,
  input  logic              wr_vld_i,
  input  logic              wr_match_i,
  input  logic [ADDR_W-1:0] key_i,
  output logic              hit_o,
  output logic              hit_match_o,
  output logic [CH_W-1:0]   hit_ch_o
);
  logic [ADDR_W-1:0] ent_addr_q [DEPTH];
  logic [CH_W-1:0]   ent_ch_q   [DEPTH];
  logic [DEPTH-1:0]  ent_vld_q;
  logic [DEPTH-1:0]  ent_match_q;
  logic [DEPTH-1:0]  hit_vec;

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ent_addr_q[g]  <= '0;
        ent_ch_q[g]    <= '0;
        ent_vld_q[g]   <= 1'b0;
        ent_match_q[g] <= 1'b0;
      end else if (wr_en_i && (wr_idx_i == IDX_W'(g))) begin
        ent_addr_q[g]  <= wr_addr_i;
        ent_ch_q[g]    <= wr_ch_i;
        ent_vld_q[g]   <= wr_vld_i;
        ent_match_q[g] <= wr_match_i;
      end
    end
    assign hit_vec[g] = ent_vld_q[g] && (ent_addr_q[g] == key_i);
  end

  // lowest index wins: scan downward so the last assignment is the lowest hit
  always_comb begin
    hit_o       = 1'b0;
    hit_match_o = 1'b0;
    hit_ch_o    = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        hit_o       = 1'b1;
        hit_match_o = ent_match_q[i];
        hit_ch_o    = ent_ch_q[i];
      end
    end
  end

  assert_tbl_write_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (ent_vld_q[$past(wr_idx_i)] == $past(wr_vld_i)) &&
                (ent_addr_q[$past(wr_idx_i)] == $past(wr_addr_i)));

  assert_hit_needs_entry_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (ent_vld_q != '0));
endmodule

// File: rtl/rxf_decide.sv
module rxf_decide
  import rxf_pkg::*;
#(
  parameter int unsigned CH_W = 3
) (
  input  logic               [ADDR_W-1:0]  addr_i,
  input  logic                             tbl_hit_i,
  input  logic                             tbl_match_i,
  input  logic               [CH_W-1:0]    tbl_ch_i,
  input  logic               [HWORD_W-1:0] hash_lo_i,
  input  logic               [HWORD_W-1:0] hash_hi_i,
  input  logic                             bc_en_i,
  input  logic               [CH_W-1:0]    bc_ch_i,
  input  logic                             mc_en_i,
  input  logic               [CH_W-1:0]    mc_ch_i,
  input  logic                             prom_en_i,
  input  logic               [CH_W-1:0]    prom_ch_i,
  output logic                             accept_o,
  output logic               [CH_W-1:0]    chan_o,
  output addr_cls_e                        cls_o
);
  logic [HMAP_W-1:0] bitmap;
  logic [HASH_W-1:0] h;
  logic is_grp, is_bc, hash_hit;

  assign bitmap   = {hash_hi_i, hash_lo_i};
  assign h        = hash_idx(addr_i);
  assign is_grp   = addr_i[0];
  assign is_bc    = &addr_i;
  assign hash_hit = is_grp && !is_bc && bitmap[h];

  always_comb begin
    cls_o = is_bc ? CLS_BCAST : (is_grp ? CLS_MULTI : CLS_UNI);
    accept_o = 1'b0;
    chan_o   = '0;
    if (tbl_hit_i) begin
      accept_o = tbl_match_i;
      chan_o   = tbl_match_i ? tbl_ch_i : '0;
    end else if (is_bc && bc_en_i) begin
      accept_o = 1'b1;
      chan_o   = bc_ch_i;
    end else if (hash_hit && mc_en_i) begin
      accept_o = 1'b1;
      chan_o   = mc_ch_i;
    end else if (prom_en_i) begin
      accept_o = 1'b1;
      chan_o   = prom_ch_i;
    end
  end
endmodule

// File: rtl/rx_dest_filter.sv
module rx_dest_filter
  import rxf_pkg::*;
#(
  parameter int unsigned TBL_DEPTH = 32,
  parameter int unsigned CH_W      = 3,
  localparam int unsigned IDX_W    = $clog2(TBL_DEPTH)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [7:0]         byte_i,
  input  logic               byte_vld_i,
  input  logic               start_i,
  input  logic               tbl_we_i,
  input  logic [IDX_W-1:0]   tbl_idx_i,
  input  logic [47:0]        tbl_addr_i,
  input  logic [CH_W-1:0]    tbl_ch_i,
  input  logic               tbl_vld_i,
  input  logic               tbl_match_i,
  input  logic [31:0]        hash_lo_i,
  input  logic [31:0]        hash_hi_i,
  input  logic               bc_en_i,
  input  logic [CH_W-1:0]    bc_ch_i,
  input  logic               mc_en_i,
  input  logic [CH_W-1:0]    mc_ch_i,
  input  logic               prom_en_i,
  input  logic [CH_W-1:0]    prom_ch_i,
  output logic               dec_vld_o,
  output logic               accept_o,
  output logic [CH_W-1:0]    chan_o,
  output logic [1:0]         cls_o
);
  logic              done;
  logic [ADDR_W-1:0] addr;
  logic              t_hit, t_match;
  logic [CH_W-1:0]   t_ch;
  logic              d_acc;
  logic [CH_W-1:0]   d_ch;
  addr_cls_e         d_cls;

  rxf_addr_asm u_asm (
    .clk_i, .rst_ni, .byte_i, .byte_vld_i, .start_i,
    .done_o (done),
    .addr_o (addr)
  );

  rxf_addr_tbl #(.DEPTH(TBL_DEPTH), .CH_W(CH_W)) u_tbl (
    .clk_i, .rst_ni,
    .wr_en_i     (tbl_we_i),
    .wr_idx_i    (tbl_idx_i),
    .wr_addr_i   (tbl_addr_i),
    .wr_ch_i     (tbl_ch_i),
    .wr_vld_i    (tbl_vld_i),
    .wr_match_i  (tbl_match_i),
    .key_i       (addr),
    .hit_o       (t_hit),
    .hit_match_o (t_match),
    .hit_ch_o    (t_ch)
  );

  rxf_decide #(.CH_W(CH_W)) u_dec (
    .addr_i      (addr),
    .tbl_hit_i   (t_hit),
    .tbl_match_i (t_match),
    .tbl_ch_i    (t_ch),
    .hash_lo_i, .hash_hi_i,
    .bc_en_i, .bc_ch_i, .mc_en_i, .mc_ch_i, .prom_en_i, .prom_ch_i,
    .accept_o    (d_acc),
    .chan_o      (d_ch),
    .cls_o       (d_cls)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dec_vld_o <= 1'b0;
      accept_o  <= 1'b0;
      chan_o    <= '0;
      cls_o     <= '0;
    end else begin
      dec_vld_o <= done;
      accept_o  <= done && d_acc;
      chan_o    <= done ? d_ch : '0;
      cls_o     <= done ? d_cls : '0;
    end
  end

  assert_quiet_outputs_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dec_vld_o |-> (!accept_o && chan_o == '0 && cls_o == '0));

  assert_single_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_vld_o |=> !dec_vld_o);

  assert_follows_byte_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dec_vld_o) |-> $past(byte_vld_i));

  assert_drop_no_chan_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_vld_o && !accept_o) |-> (chan_o == '0));
endmodule

// File: tb/rx_dest_filter_tb.sv
`timescale 1ns/1ps
module rx_dest_filter_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  byte_d = '0;
  logic        vld = 1'b0, st = 1'b0;
  logic        we = 1'b0;
  logic [4:0]  widx = '0;
  logic [47:0] waddr = '0;
  logic [2:0]  wch = '0;
  logic        wvld = 1'b0, wmatch = 1'b0;
  logic [31:0] hlo = '0, hhi = '0;
  logic        bc_en = 1'b0, mc_en = 1'b0, pr_en = 1'b0;
  logic [2:0]  bc_ch = '0, mc_ch = '0, pr_ch = '0;
  logic        dec_vld, acc;
  logic [2:0]  chan;
  logic [1:0]  cls;

  always #2.5 clk = ~clk;

  rx_dest_filter u_dut (
    .clk_i(clk), .rst_ni(rst_n), .byte_i(byte_d), .byte_vld_i(vld), .start_i(st),
    .tbl_we_i(we), .tbl_idx_i(widx), .tbl_addr_i(waddr), .tbl_ch_i(wch),
    .tbl_vld_i(wvld), .tbl_match_i(wmatch), .hash_lo_i(hlo), .hash_hi_i(hhi),
    .bc_en_i(bc_en), .bc_ch_i(bc_ch), .mc_en_i(mc_en), .mc_ch_i(mc_ch),
    .prom_en_i(pr_en), .prom_ch_i(pr_ch),
    .dec_vld_o(dec_vld), .accept_o(acc), .chan_o(chan), .cls_o(cls)
  );

  // ---------------- reference model ----------------
  logic [47:0] m_addr [32];
  logic [2:0]  m_ch [32];
  bit          m_vld [32];
  bit          m_match [32];
  int          m_cnt = 0;
  bit          m_rs = 0;
  logic [47:0] m_acc = '0;
  bit          e_vld = 0, e_acc = 0;
  logic [2:0]  e_ch = '0;
  logic [1:0]  e_cls = '0;
  string       e_tag = "R1";
  int          n_vec = 0, n_bad = 0;
  bit          finished = 0;

  task automatic model_decide();
    int hit;
    logic [5:0] h;
    logic [63:0] map;
    bit bc, grp;
    hit = -1;
    for (int i = 31; i >= 0; i--)
      if (m_vld[i] && m_addr[i] == m_acc) hit = i;
    h = '0;
    for (int b = 0; b < 48; b++) h[b % 6] = h[b % 6] ^ m_acc[b];
    map = {hhi, hlo};
    bc  = (m_acc == {48{1'b1}});
    grp = m_acc[0];
    e_vld = 1;
    e_cls = bc ? 2'd2 : (grp ? 2'd1 : 2'd0);
    e_acc = 0; e_ch = '0;
    if (hit >= 0) begin
      if (m_match[hit]) begin e_acc = 1; e_ch = m_ch[hit]; e_tag = "R4"; end
      else e_tag = "R5";
    end else if (bc && bc_en) begin e_acc = 1; e_ch = bc_ch; e_tag = "R6"; end
    else if (grp && !bc && mc_en && map[h]) begin e_acc = 1; e_ch = mc_ch; e_tag = "R7"; end
    else if (pr_en) begin e_acc = 1; e_ch = pr_ch; e_tag = "R8"; end
    else e_tag = "R9";
    if (we && waddr == m_acc) e_tag = "R10";
    if (m_rs) e_tag = "R11";
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 32; i++) begin m_vld[i] = 0; m_match[i] = 0; m_ch[i] = '0; m_addr[i] = '0; end
      m_cnt = 0; m_rs = 0; m_acc = '0;
      e_vld = 0; e_acc = 0; e_ch = '0; e_cls = '0; e_tag = "R1";
    end else begin
      e_vld = 0; e_acc = 0; e_ch = '0; e_cls = '0; e_tag = "R2";
      if (vld) begin
        if (st) begin
          m_rs = (m_cnt != 0);
          m_acc = '0; m_acc[7:0] = byte_d; m_cnt = 1;
        end else if (m_cnt != 0) begin
          m_acc[8*m_cnt +: 8] = byte_d;
          m_cnt++;
          if (m_cnt == 6) begin model_decide(); m_cnt = 0; m_rs = 0; end
        end
      end
      // write applied after the lookup of the same edge (R10)
      if (we) begin
        m_vld[widx] = wvld; m_match[widx] = wmatch; m_ch[widx] = wch; m_addr[widx] = waddr;
      end
    end
  end

  // compare every clock, away from the active edge; class mismatches are R3
  always @(negedge clk) begin
    if (!finished) begin
      n_vec++;
      if (dec_vld !== e_vld || acc !== e_acc || chan !== e_ch || cls !== e_cls) begin
        n_bad++;
        $display("FAIL %s: got vld=%0b acc=%0b ch=%0d cls=%0d exp vld=%0b acc=%0b ch=%0d cls=%0d",
                 (e_vld && dec_vld && acc === e_acc && chan === e_ch) ? "R3" : e_tag,
                 dec_vld, acc, chan, cls, e_vld, e_acc, e_ch, e_cls);
      end
    end
  end

  // ---------------- stimulus ----------------
  bit gaps = 0;

  task automatic drive_byte(input logic [7:0] b, input bit s);
    @(negedge clk);
    byte_d = b; vld = 1; st = s;
    if (gaps && ($urandom % 3 == 0)) begin
      @(negedge clk); vld = 0; st = 0;
      @(negedge clk); vld = 1; st = s;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(negedge clk); vld = 0; st = 0; we = 0; end
  endtask

  task automatic send(input logic [47:0] a);
    for (int k = 0; k < 6; k++) drive_byte(a[8*k +: 8], k == 0);
    idle(1);
  endtask

  task automatic tbl_wr(input int i, input logic [47:0] a, input logic [2:0] c,
                        input bit v, input bit m);
    @(negedge clk);
    vld = 0; st = 0;
    we = 1; widx = 5'(i); waddr = a; wch = c; wvld = v; wmatch = m;
    @(negedge clk); we = 0;
  endtask

  localparam logic [47:0] A  = 48'h0000_3344_5502;
  localparam logic [47:0] B  = 48'h6677_8899_AA10;
  localparam logic [47:0] C  = 48'h1234_5678_9ABC;
  localparam logic [47:0] D  = 48'h0F0E_0D0C_0B0A;
  localparam logic [47:0] E  = 48'hCAFE_0000_0042;
  localparam logic [47:0] M  = 48'h0000_5E00_0001;
  localparam logic [47:0] U  = 48'h0102_0304_0506;
  localparam logic [47:0] BC = 48'hFFFF_FFFF_FFFF;

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_bad++;
      $display("FAIL watchdog: got running exp finished");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);       // R1: reset state compared each clock
    rst_n = 1;
    idle(3);
    send(U);                          // R9: empty table, nothing enabled
    send(A);
    tbl_wr(0, A, 3'd3, 1, 1);
    tbl_wr(5, B, 3'd1, 1, 0);
    tbl_wr(7, C, 3'd2, 1, 1);
    tbl_wr(9, C, 3'd6, 1, 1);
    tbl_wr(31, D, 3'd5, 1, 1);
    send(A);                          // R4
    send(C);                          // R4 lowest index
    send(D);
    pr_en = 1; pr_ch = 3'd4;
    send(B);                          // R5 beats promiscuous
    send(U);                          // R8
    bc_en = 1; bc_ch = 3'd6;
    send(BC);                         // R6
    bc_en = 0;
    send(BC);                         // R6 disabled -> R8
    pr_en = 0;
    send(BC);                         // R9
    mc_en = 1; mc_ch = 3'd7; hlo = '1; hhi = '1;
    send(M);                          // R7
    hlo = '0; hhi = '0;
    send(M);                          // R7 bit clear -> R9
    hhi = 32'hAAAA_5555; hlo = 32'h0F0F_F0F0;
    send(M);
    // R11 restart after three bytes
    drive_byte(8'h11, 1); drive_byte(8'h22, 0); drive_byte(8'h33, 0);
    send(A);
    // R2 trailing bytes ignored, back to back frames
    for (int k = 0; k < 6; k++) drive_byte(C[8*k +: 8], k == 0);
    drive_byte(8'hFF, 0); drive_byte(8'hFF, 0); drive_byte(8'h01, 0);
    for (int k = 0; k < 6; k++) drive_byte(D[8*k +: 8], k == 0);
    for (int k = 0; k < 6; k++) drive_byte(A[8*k +: 8], k == 0);
    idle(2);
    // R10 write on the same edge as the last byte of E
    for (int k = 0; k < 5; k++) drive_byte(E[8*k +: 8], k == 0);
    @(negedge clk);
    byte_d = E[47:40]; vld = 1; st = 0;
    we = 1; widx = 5'd12; waddr = E; wch = 3'd5; wvld = 1; wmatch = 1;
    idle(1);
    send(E);                          // now hits entry 12
    tbl_wr(20, BC, 3'd1, 1, 0);
    bc_en = 1;
    send(BC);                         // R5 table drop beats broadcast
    tbl_wr(0, A, 3'd3, 0, 1);
    send(A);                          // invalidated entry
    // randomized traffic
    gaps = 1;
    for (int n = 0; n < 400; n++) begin
      logic [47:0] a;
      int sel;
      sel = $urandom % 8;
      case (sel)
        0: a = A; 1: a = C; 2: a = BC; 3: a = E;
        4: a = {$urandom, $urandom} | 48'h1;
        default: a = {$urandom, $urandom};
      endcase
      if ($urandom % 5 == 0) begin
        bc_en = 1'($urandom); mc_en = 1'($urandom); pr_en = 1'($urandom);
        bc_ch = 3'($urandom); mc_ch = 3'($urandom); pr_ch = 3'($urandom);
        hlo = $urandom; hhi = $urandom;
      end
      if ($urandom % 4 == 0)
        tbl_wr($urandom % 32, ($urandom % 2) ? a : {$urandom, $urandom},
               3'($urandom), 1'($urandom), 1'($urandom));
      if ($urandom % 6 == 0) begin
        for (int k = 0; k < 5; k++) drive_byte(a[8*k +: 8], k == 0);
        @(negedge clk);
        byte_d = a[47:40]; vld = 1; st = 0;
        we = 1; widx = 5'($urandom); waddr = a; wch = 3'($urandom);
        wvld = 1'($urandom); wmatch = 1'($urandom);
        idle(1);
      end else begin
        send(a);
      end
    end
    idle(4);
    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule